// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps the results of instructions that have finished executing but may not yet change machine state. Each instruction claims a slot at issue time, in program order, and the slot number it receives becomes the tag under which its result is later delivered and under which waiting instructions look up their operands. Results arrive in any order; retirement happens strictly in order, one slot per cycle, from the oldest slot.

Retirement of a register-writing slot updates the register file. Retirement of a store lets the store go to memory once both its data and its address have arrived. Retirement of a branch confirms it or, when the branch was guessed wrong, discards every younger slot. A faulting instruction is reported only when it becomes the oldest slot; it makes no state change and also discards everything younger. Issue logic sees a one-cycle discard pulse and resumes allocating from the slot after the retired one.

Top module: `speculative_rob`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `rf_we`, `st_release`, `br_resolve`, `flush` and `exc_raise` are all 0.
- R2: An accepted allocation (`alloc_valid` and `alloc_ready` both 1) takes the slot shown on `alloc_tag`; successive allocations receive consecutive slot numbers, wrapping from DEPTH-1 to 0. Kind encoding on `alloc_kind`: 0 = register write, 1 = store, 2 = branch.
- R3: While all DEPTH slots are occupied `alloc_ready` is 0 and a request is not accepted; the slot number on `alloc_tag` does not advance.
- R4: Retirement is in order: a slot retires only when it is the oldest and its result is present, at most one slot per cycle; a younger finished slot waits behind an unfinished older one.
- R5: A retiring register-write slot without fault drives `rf_we` = 1 with `rf_dest` and `rf_data` equal to the destination given at allocation and the value given at completion.
- R6: A store slot retires only after both its data (through the completion port) and its address (through the store-address port) have arrived; it then drives `st_release` = 1 with `st_data` and `st_addr`.
- R7: A retiring branch completed with `cpl_mispredict` = 0 drives `br_resolve` = 1 and `flush` = 0.
- R8: A retiring branch completed with `cpl_mispredict` = 1 drives `flush` = 1 for that cycle; all younger slots are discarded, `alloc_ready` is 0 in that cycle, and the next `alloc_tag` is the slot after the branch.
- R9: A slot completed with `cpl_fault` = 1 raises `exc_raise` and `flush` only when it is the oldest slot, with no register write and no store release; younger slots are discarded.
- R10: A completion or store address aimed at a slot that is not occupied (never allocated, or discarded by a flush) has no effect: no later retirement is caused by it.
- R11: The lookup port reports `rd_ready` = 1 and the stored result on `rd_value` for an occupied slot whose result has arrived, and `rd_ready` = 0 before the result arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Issue requests a slot |
| alloc_kind | input | 2 | Instruction kind: 0 register, 1 store, 2 branch |
| alloc_dest | input | REG_W | Destination register number |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | IDX_W | Slot number granted to the request |
| cpl_valid | input | 1 | Execution result arrives |
| cpl_tag | input | IDX_W | Slot the result belongs to |
| cpl_value | input | DATA_W | Result value, or store data |
| cpl_mispredict | input | 1 | Branch was guessed wrong |
| cpl_fault | input | 1 | Instruction faulted |
| sta_valid | input | 1 | Store address arrives |
| sta_tag | input | IDX_W | Slot of the store |
| sta_addr | input | ADDR_W | Store address |
| rd_tag | input | IDX_W | Slot looked up for an operand |
| rd_ready | output | 1 | Looked-up result is present |
| rd_value | output | DATA_W | Looked-up result |
| commit_tag | output | IDX_W | Slot number of the oldest slot |
| rf_we | output | 1 | Register file write at retirement |
| rf_dest | output | REG_W | Register written |
| rf_data | output | DATA_W | Value written |
| st_release | output | 1 | Store allowed to proceed to memory |
| st_addr | output | ADDR_W | Released store address |
| st_data | output | DATA_W | Released store data |
| br_resolve | output | 1 | Branch retired |
| flush | output | 1 | Younger slots discarded this cycle |
| exc_raise | output | 1 | Fault taken at retirement |

## Verification
On every cycle the assertions check that the buffer never holds more than DEPTH slots and refuses allocation when full, that at most one kind of retirement happens per cycle, that a fault never writes state, and that a flush blocks allocation and leaves the buffer empty one cycle later. Only the bench's scenarios can show the data paths: which slot number each allocation receives, that retirement waits for the oldest slot and for both halves of a store, that retired values and registers match what was delivered, and that results sent to discarded slots stay without effect.

// File: rtl/rob_pkg.sv
package rob_pkg;
   typedef enum logic [1:0] {
      KIND_REG    = 2'd0,
      KIND_STORE  = 2'd1,
      KIND_BRANCH = 2'd2
   } rob_kind_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
// Oldest/youngest slot pointers and occupancy of the circular buffer.
module rob_ptr_ctrl #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_req,
   input  logic             retire,
   input  logic             discard,
   output logic [IDX_W-1:0] head,
   output logic [IDX_W-1:0] tail,
   output logic [CNT_W-1:0] occ,
   output logic             alloc_ok
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic take;

   assign alloc_ok = (occ != FULL_CNT) && !discard;
   assign take     = alloc_req && alloc_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
         occ  <= '0;
      end else if (discard) begin
         // the retiring slot leaves too; issue restarts right after it
         head <= head + 1'b1;
         tail <= head + 1'b1;
         occ  <= '0;
      end else begin
         if (retire) head <= head + 1'b1;
         if (take)   tail <= tail + 1'b1;
         occ <= occ + CNT_W'(take) - CNT_W'(retire);
      end
   end
endmodule

// File: rtl/rob_entry_array.sv
// Slot storage: one generated slot per entry, plus head and lookup read-out.
module rob_entry_array
   import rob_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int REG_W  = 6,
   parameter int DATA_W = 64,
   parameter int ADDR_W = 48,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_fire,
   input  logic [IDX_W-1:0]  tail,
   input  rob_kind_e         alloc_kind,
   input  logic [REG_W-1:0]  alloc_dest,
   input  logic              cpl_valid,
   input  logic [IDX_W-1:0]  cpl_tag,
   input  logic [DATA_W-1:0] cpl_value,
   input  logic              cpl_mispredict,
   input  logic              cpl_fault,
   input  logic              sta_valid,
   input  logic [IDX_W-1:0]  sta_tag,
   input  logic [ADDR_W-1:0] sta_addr,
   input  logic              retire,
   input  logic              discard,
   input  logic [IDX_W-1:0]  head,
   input  logic [IDX_W-1:0]  rd_tag,
   output logic              h_valid,
   output logic              h_ready,
   output rob_kind_e         h_kind,
   output logic [REG_W-1:0]  h_dest,
   output logic [DATA_W-1:0] h_value,
   output logic [ADDR_W-1:0] h_addr,
   output logic              h_mispred,
   output logic              h_fault,
   output logic              rd_ready,
   output logic [DATA_W-1:0] rd_value
);
   logic [DEPTH-1:0] v_vec, rdy_vec, done_vec, mis_vec, flt_vec;
   rob_kind_e        kind_arr [DEPTH];
   logic [REG_W-1:0] dest_arr [DEPTH];
   logic [DATA_W-1:0] data_arr [DEPTH];
   logic [ADDR_W-1:0] addr_arr [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
      logic              valid_r, done_r, aok_r, mis_r, flt_r;
      rob_kind_e         kind_r;
      logic [REG_W-1:0]  dest_r;
      logic [DATA_W-1:0] data_r;
      logic [ADDR_W-1:0] addr_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_r <= 1'b0;
            done_r  <= 1'b0;
            aok_r   <= 1'b0;
            mis_r   <= 1'b0;
            flt_r   <= 1'b0;
            kind_r  <= KIND_REG;
            dest_r  <= '0;
            data_r  <= '0;
            addr_r  <= '0;
         end else if (discard) begin
            valid_r <= 1'b0;
         end else begin
            if (retire && head == MY_IDX)
               valid_r <= 1'b0;
            if (alloc_fire && tail == MY_IDX) begin
               valid_r <= 1'b1;
               kind_r  <= alloc_kind;
               dest_r  <= alloc_dest;
               done_r  <= 1'b0;
               aok_r   <= 1'b0;
               mis_r   <= 1'b0;
               flt_r   <= 1'b0;
            end
            if (cpl_valid && cpl_tag == MY_IDX && valid_r) begin
               done_r <= 1'b1;
               data_r <= cpl_value;
               mis_r  <= cpl_mispredict;
               flt_r  <= cpl_fault;
            end
            if (sta_valid && sta_tag == MY_IDX && valid_r) begin
               aok_r  <= 1'b1;
               addr_r <= sta_addr;
            end
         end
      end

      assign v_vec[i]    = valid_r;
      assign done_vec[i] = done_r;
      assign rdy_vec[i]  = done_r && (kind_r != KIND_STORE || aok_r);
      assign mis_vec[i]  = mis_r;
      assign flt_vec[i]  = flt_r;
      assign kind_arr[i] = kind_r;
      assign dest_arr[i] = dest_r;
      assign data_arr[i] = data_r;
      assign addr_arr[i] = addr_r;
   end

   assign h_valid   = v_vec[head];
   assign h_ready   = rdy_vec[head];
   assign h_kind    = kind_arr[head];
   assign h_dest    = dest_arr[head];
   assign h_value   = data_arr[head];
   assign h_addr    = addr_arr[head];
   assign h_mispred = mis_vec[head];
   assign h_fault   = flt_vec[head];

   assign rd_ready  = v_vec[rd_tag] && done_vec[rd_tag];
   assign rd_value  = data_arr[rd_tag];
endmodule

// File: rtl/rob_commit_logic.sv
// Decides what the oldest slot does when it retires.
module rob_commit_logic
   import rob_pkg::*;
(
   input  logic      h_valid,
   input  logic      h_ready,
   input  rob_kind_e h_kind,
   input  logic      h_mispred,
   input  logic      h_fault,
   output logic      retire,
   output logic      discard,
   output logic      do_rf,
   output logic      do_st,
   output logic      do_br,
   output logic      do_exc
);
   always_comb begin
      retire  = h_valid && h_ready;
      do_exc  = retire && h_fault;
      do_rf   = retire && !h_fault && h_kind == KIND_REG;
      do_st   = retire && !h_fault && h_kind == KIND_STORE;
      do_br   = retire && !h_fault && h_kind == KIND_BRANCH;
      discard = do_exc || (do_br && h_mispred);
   end
endmodule

// File: rtl/speculative_rob.sv
module speculative_rob
   import rob_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int REG_W  = 6,
   parameter int DATA_W = 64,
   parameter int ADDR_W = 48,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic [1:0]        alloc_kind,
   input  logic [REG_W-1:0]  alloc_dest,
   output logic              alloc_ready,
   output logic [IDX_W-1:0]  alloc_tag,
   input  logic              cpl_valid,
   input  logic [IDX_W-1:0]  cpl_tag,
   input  logic [DATA_W-1:0] cpl_value,
   input  logic              cpl_mispredict,
   input  logic              cpl_fault,
   input  logic              sta_valid,
   input  logic [IDX_W-1:0]  sta_tag,
   input  logic [ADDR_W-1:0] sta_addr,
   input  logic [IDX_W-1:0]  rd_tag,
   output logic              rd_ready,
   output logic [DATA_W-1:0] rd_value,
   output logic [IDX_W-1:0]  commit_tag,
   output logic              rf_we,
   output logic [REG_W-1:0]  rf_dest,
   output logic [DATA_W-1:0] rf_data,
   output logic              st_release,
   output logic [ADDR_W-1:0] st_addr,
   output logic [DATA_W-1:0] st_data,
   output logic              br_resolve,
   output logic              flush,
   output logic              exc_raise
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("speculative_rob: DEPTH must be a power of two of at least 2");
   end
   if (REG_W < 1 || DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("speculative_rob: widths must be positive");
   end

   logic [IDX_W-1:0]  head, tail;
   logic [CNT_W-1:0]  occ;
   logic              alloc_ok, alloc_fire;
   logic              retire, discard, do_rf, do_st, do_br, do_exc;
   logic              h_valid, h_ready, h_mispred, h_fault;
   rob_kind_e         h_kind;
   logic [REG_W-1:0]  h_dest;
   logic [DATA_W-1:0] h_value;
   logic [ADDR_W-1:0] h_addr;

   assign alloc_fire = alloc_valid && alloc_ok;

   rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk, .rst_n,
      .alloc_req (alloc_valid),
      .retire    (retire),
      .discard   (discard),
      .head      (head),
      .tail      (tail),
      .occ       (occ),
      .alloc_ok  (alloc_ok)
   );

   rob_entry_array #(
      .DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_slots (
      .clk, .rst_n,
      .alloc_fire     (alloc_fire),
      .tail           (tail),
      .alloc_kind     (rob_kind_e'(alloc_kind)),
      .alloc_dest     (alloc_dest),
      .cpl_valid      (cpl_valid),
      .cpl_tag        (cpl_tag),
      .cpl_value      (cpl_value),
      .cpl_mispredict (cpl_mispredict),
      .cpl_fault      (cpl_fault),
      .sta_valid      (sta_valid),
      .sta_tag        (sta_tag),
      .sta_addr       (sta_addr),
      .retire         (retire),
      .discard        (discard),
      .head           (head),
      .rd_tag         (rd_tag),
      .h_valid        (h_valid),
      .h_ready        (h_ready),
      .h_kind         (h_kind),
      .h_dest         (h_dest),
      .h_value        (h_value),
      .h_addr         (h_addr),
      .h_mispred      (h_mispred),
      .h_fault        (h_fault),
      .rd_ready       (rd_ready),
      .rd_value       (rd_value)
   );

   rob_commit_logic u_commit (
      .h_valid   (h_valid),
      .h_ready   (h_ready),
      .h_kind    (h_kind),
      .h_mispred (h_mispred),
      .h_fault   (h_fault),
      .retire    (retire),
      .discard   (discard),
      .do_rf     (do_rf),
      .do_st     (do_st),
      .do_br     (do_br),
      .do_exc    (do_exc)
   );

   assign alloc_ready = alloc_ok;
   assign alloc_tag   = tail;
   assign commit_tag  = head;
   assign rf_we       = do_rf;
   assign rf_dest     = h_dest;
   assign rf_data     = h_value;
   assign st_release  = do_st;
   assign st_addr     = h_addr;
   assign st_data     = h_value;
   assign br_resolve  = do_br;
   assign flush       = discard;
   assign exc_raise   = do_exc;
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             alloc_ready,
   input logic             rf_we,
   input logic             st_release,
   input logic             br_resolve,
   input logic             flush,
   input logic             exc_raise,
   input logic [CNT_W-1:0] occ
);
   // R3: never more slots in use than exist
   a_r3_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CNT_W'(DEPTH));

   // R3: a full buffer refuses allocation
   a_r3_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
      occ == CNT_W'(DEPTH) |-> !alloc_ready);

   // R4: one retirement action at most per cycle
   a_r4_single_retire: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rf_we, st_release, br_resolve, exc_raise}));

   // R8: discarding blocks allocation in the same cycle
   a_r8_flush_blocks_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !alloc_ready);

   // R8: after a discard the buffer is empty
   a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> occ == '0);

   // R9: a fault discards and changes no state
   a_r9_fault_no_state: assert property (@(posedge clk) disable iff (!rst_n)
      exc_raise |-> flush && !rf_we && !st_release);
endmodule

bind speculative_rob rob_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rob_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .alloc_ready (alloc_ready),
   .rf_we       (rf_we),
   .st_release  (st_release),
   .br_resolve  (br_resolve),
   .flush       (flush),
   .exc_raise   (exc_raise),
   .occ         (occ)
);

// File: tb/speculative_rob_test.sv
module speculative_rob_test;
   localparam int DEPTH  = 4;
   localparam int REG_W  = 5;
   localparam int DATA_W = 16;
   localparam int ADDR_W = 8;
   localparam int IDX_W  = 2;

   typedef struct packed {
      logic        a_v;  logic [1:0] a_k;  logic [4:0] a_d;
      logic        c_v;  logic [1:0] c_t;  logic [15:0] c_val; logic c_m; logic c_f;
      logic        s_v;  logic [1:0] s_t;  logic [7:0] s_a;
      logic        e_ar; logic [1:0] e_at; logic e_rf; logic [4:0] e_rd;
      logic [15:0] e_dat; logic [7:0] e_adr;
      logic        e_st; logic e_br; logic e_fl; logic e_ex;
   } vec_t;

   localparam int NV = 25;
   // fields: alloc(v,kind,dest) cpl(v,tag,val,mis,flt) sta(v,tag,addr) |
   //         expect(ready,tag,rf,dest,data,addr,st,br,flush,exc)
   localparam vec_t VECS [NV] = '{
      '{1,0,3, 0,0,16'h0,0,0, 0,0,8'h0,  1,0,0,0,16'h0,8'h0,0,0,0,0},    // 0  R2 first slot
      '{1,1,0, 1,0,16'h1111,0,0, 0,0,8'h0, 1,1,0,0,16'h0,8'h0,0,0,0,0}, // 1  R2
      '{1,2,0, 0,0,16'h0,0,0, 1,1,8'h40, 1,2,1,3,16'h1111,8'h0,0,0,0,0},// 2  R5 register retire
      '{1,0,7, 1,1,16'h2222,0,0, 0,0,8'h0, 1,3,0,0,16'h0,8'h0,0,0,0,0}, // 3  R2
      '{1,0,9, 0,0,16'h0,0,0, 0,0,8'h0,  1,0,0,0,16'h2222,8'h40,1,0,0,0},// 4 R6 store, R2 wrap
      '{1,0,10, 0,0,16'h0,0,0, 0,0,8'h0, 1,1,0,0,16'h0,8'h0,0,0,0,0},   // 5  R4 branch not done
      '{1,0,11, 1,3,16'h3333,0,0, 0,0,8'h0, 0,2,0,0,16'h0,8'h0,0,0,0,0},// 6  R3 full
      '{0,0,0, 1,2,16'h0,1,0, 0,0,8'h0,  0,2,0,0,16'h0,8'h0,0,0,0,0},   // 7  R4 younger waits
      '{0,0,0, 1,0,16'h4444,0,0, 0,0,8'h0, 0,2,0,0,16'h0,8'h0,0,1,1,0}, // 8  R8 mispredict
      '{0,0,0, 1,3,16'h5555,0,0, 0,0,8'h0, 1,3,0,0,16'h0,8'h0,0,0,0,0}, // 9  R8 restart, R10
      '{0,0,0, 0,0,16'h0,0,0, 0,0,8'h0,  1,3,0,0,16'h0,8'h0,0,0,0,0},   // 10 R10 stale ignored
      '{1,0,5, 0,0,16'h0,0,0, 0,0,8'h0,  1,3,0,0,16'h0,8'h0,0,0,0,0},   // 11 R2
      '{0,0,0, 1,3,16'h6666,0,1, 0,0,8'h0, 1,0,0,0,16'h0,8'h0,0,0,0,0}, // 12 R9
      '{1,0,6, 0,0,16'h0,0,0, 0,0,8'h0,  0,0,0,0,16'h0,8'h0,0,0,1,1},   // 13 R9 fault at head
      '{0,0,0, 1,0,16'h7777,0,0, 0,0,8'h0, 1,0,0,0,16'h0,8'h0,0,0,0,0}, // 14 R10 refused slot
      '{0,0,0, 0,0,16'h0,0,0, 0,0,8'h0,  1,0,0,0,16'h0,8'h0,0,0,0,0},   // 15 R10
      '{1,1,0, 0,0,16'h0,0,0, 0,0,8'h0,  1,0,0,0,16'h0,8'h0,0,0,0,0},   // 16 R6
      '{0,0,0, 1,0,16'h8888,0,0, 0,0,8'h0, 1,1,0,0,16'h0,8'h0,0,0,0,0}, // 17 R6
      '{0,0,0, 0,0,16'h0,0,0, 0,0,8'h0,  1,1,0,0,16'h0,8'h0,0,0,0,0},   // 18 R6 no address yet
      '{0,0,0, 0,0,16'h0,0,0, 1,0,8'h55, 1,1,0,0,16'h0,8'h0,0,0,0,0},   // 19 R6
      '{0,0,0, 0,0,16'h0,0,0, 0,0,8'h0,  1,1,0,0,16'h8888,8'h55,1,0,0,0},// 20 R6 released
      '{1,2,0, 0,0,16'h0,0,0, 0,0,8'h0,  1,1,0,0,16'h0,8'h0,0,0,0,0},   // 21 R7
      '{0,0,0, 1,1,16'h0,0,0, 0,0,8'h0,  1,2,0,0,16'h0,8'h0,0,0,0,0},   // 22 R7
      '{0,0,0, 0,0,16'h0,0,0, 0,0,8'h0,  1,2,0,0,16'h0,8'h0,0,1,0,0},   // 23 R7 correct branch
      '{0,0,0, 0,0,16'h0,0,0, 0,0,8'h0,  1,2,0,0,16'h0,8'h0,0,0,0,0}    // 24 R4 nothing left
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic alloc_valid = 1'b0;
   logic [1:0] alloc_kind = '0;
   logic [REG_W-1:0] alloc_dest = '0;
   logic alloc_ready;
   logic [IDX_W-1:0] alloc_tag;
   logic cpl_valid = 1'b0;
   logic [IDX_W-1:0] cpl_tag = '0;
   logic [DATA_W-1:0] cpl_value = '0;
   logic cpl_mispredict = 1'b0, cpl_fault = 1'b0;
   logic sta_valid = 1'b0;
   logic [IDX_W-1:0] sta_tag = '0;
   logic [ADDR_W-1:0] sta_addr = '0;
   logic [IDX_W-1:0] rd_tag = '0;
   logic rd_ready;
   logic [DATA_W-1:0] rd_value;
   logic [IDX_W-1:0] commit_tag;
   logic rf_we, st_release, br_resolve, flush, exc_raise;
   logic [REG_W-1:0] rf_dest;
   logic [DATA_W-1:0] rf_data, st_data;
   logic [ADDR_W-1:0] st_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;

   always #2 clk = ~clk;

   speculative_rob #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
      .clk, .rst_n, .alloc_valid, .alloc_kind, .alloc_dest, .alloc_ready, .alloc_tag,
      .cpl_valid, .cpl_tag, .cpl_value, .cpl_mispredict, .cpl_fault,
      .sta_valid, .sta_tag, .sta_addr, .rd_tag, .rd_ready, .rd_value, .commit_tag,
      .rf_we, .rf_dest, .rf_data, .st_release, .st_addr, .st_data,
      .br_resolve, .flush, .exc_raise
   );

   task automatic idle_inputs();
      alloc_valid = 1'b0; cpl_valid = 1'b0; sta_valid = 1'b0;
      cpl_mispredict = 1'b0; cpl_fault = 1'b0;
   endtask

   // R1 style check of the quiet state
   task automatic check_quiet(input string req, input logic [IDX_W-1:0] exp_tag);
      n_chk++;
      if (!(alloc_ready && alloc_tag == exp_tag && !rf_we && !st_release &&
            !br_resolve && !flush && !exc_raise)) begin
         n_bad++;
         $display("FAIL %s: ready=%0b tag=%0d rf=%0b st=%0b br=%0b fl=%0b ex=%0b, expected ready=1 tag=%0d and no retirement",
                  req, alloc_ready, alloc_tag, rf_we, st_release, br_resolve, flush, exc_raise, exp_tag);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not end, expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check_quiet("R1 reset", '0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         alloc_valid = VECS[k].a_v; alloc_kind = VECS[k].a_k; alloc_dest = VECS[k].a_d;
         cpl_valid = VECS[k].c_v; cpl_tag = VECS[k].c_t; cpl_value = VECS[k].c_val;
         cpl_mispredict = VECS[k].c_m; cpl_fault = VECS[k].c_f;
         sta_valid = VECS[k].s_v; sta_tag = VECS[k].s_t; sta_addr = VECS[k].s_a;
         #1;
         n_chk++;
         if (!(alloc_ready == VECS[k].e_ar && alloc_tag == VECS[k].e_at &&
               rf_we == VECS[k].e_rf && st_release == VECS[k].e_st &&
               br_resolve == VECS[k].e_br && flush == VECS[k].e_fl &&
               exc_raise == VECS[k].e_ex &&
               (!VECS[k].e_rf || (rf_dest == VECS[k].e_rd && rf_data == VECS[k].e_dat)) &&
               (!VECS[k].e_st || (st_data == VECS[k].e_dat && st_addr == VECS[k].e_adr)))) begin
            n_bad++;
            $display("FAIL vector %0d (R2..R10 per table note): ar=%0b at=%0d rf=%0b rd=%0d dat=%h st=%0b sd=%h sa=%h br=%0b fl=%0b ex=%0b ; expected ar=%0b at=%0d rf=%0b rd=%0d dat=%h st=%0b adr=%h br=%0b fl=%0b ex=%0b",
                     k, alloc_ready, alloc_tag, rf_we, rf_dest, rf_data, st_release, st_data, st_addr,
                     br_resolve, flush, exc_raise,
                     VECS[k].e_ar, VECS[k].e_at, VECS[k].e_rf, VECS[k].e_rd, VECS[k].e_dat,
                     VECS[k].e_st, VECS[k].e_adr, VECS[k].e_br, VECS[k].e_fl, VECS[k].e_ex);
         end
      end

      // R11: operand lookup; the buffer is empty with next slot 2
      @(negedge clk);
      idle_inputs();
      alloc_valid = 1'b1; alloc_kind = 2'd0; alloc_dest = 5'd12;
      @(negedge clk);
      idle_inputs();
      rd_tag = 2'd2;
      #1;
      n_chk++;
      if (rd_ready !== 1'b0) begin
         n_bad++;
         $display("FAIL R11 before result: rd_ready=%0b expected 0", rd_ready);
      end
      cpl_valid = 1'b1; cpl_tag = 2'd2; cpl_value = 16'hABCD;
      @(negedge clk);
      idle_inputs();
      #1;
      n_chk++;
      if (!(rd_ready && rd_value == 16'hABCD)) begin
         n_bad++;
         $display("FAIL R11 after result: rd_ready=%0b rd_value=%h expected 1 abcd", rd_ready, rd_value);
      end
      n_chk++;
      if (!(rf_we && rf_dest == 5'd12 && rf_data == 16'hABCD)) begin
         n_bad++;
         $display("FAIL R5 lookup slot retire: rf=%0b rd=%0d dat=%h expected 1 12 abcd", rf_we, rf_dest, rf_data);
      end

      // R1: reset in mid-run returns to the empty state
      @(negedge clk);
      alloc_valid = 1'b1; alloc_kind = 2'd0; alloc_dest = 5'd1;
      @(negedge clk);
      idle_inputs();
      rst_n = 1'b0;
      #1;
      check_quiet("R1 reset mid-run", '0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_quiet("R1 after release", '0);

      done_flag = 1'b1;
      finish_run();
   end
endmodule